// File: doc/BRIEF.md
# Four-Channel DMA Transfer Engine

This block runs the per-channel transfer arithmetic of a four-channel DMA controller. Each channel holds a base address, a base element count, a live (current) address, a live count and a mode byte. A host register decoder elsewhere loads these through a narrow configuration port. A requester asks for a transfer by giving a channel number and the number of elements it wants. The engine decides how many elements it will grant, then moves one element per clock. For each element it raises a memory write or read strobe with the element's address, steps the live address and decrements the live count.

The outcome is decided entirely by the channel's mask bit and its mode byte. Only single-transfer operation moves data. Demand, block and cascade operation are refused with a zero grant, and so is the illegal transfer type, which also raises an error. When the live count of a channel runs out, the engine sets the channel's finished flag and drops its pending-request flag. If the channel's mode asks for it, the engine also restores the live registers from the base registers, so the same buffer can be cycled through again.

Top module: `dmaxfer_engine`

## Requirements
- R1: After reset every live address, live count, mode byte, finished flag and request flag is zero, and busy, done and both strobes are low. Because the mode byte is zero, a request made before any mode is programmed is granted zero elements.
- R2: A configuration write with `cfg_sel` = 0 loads the channel's base address and also its live address. With `cfg_sel` = 1 it loads the base count and the live count, and clears the channel's finished flag. With `cfg_sel` = 2 it loads the mode byte from `cfg_data[7:0]`. The code 3 writes nothing.
- R3: A request on a channel whose `chan_mask` bit is 1 is granted zero elements, produces no strobe, and leaves that channel's live address and count unchanged.
- R4: Mode bits 7:6 select the operating mode: 01 is single-transfer, and 00, 10 and 11 are refused. A refused mode gets a zero grant, no strobe and no register change.
- R5: Mode bits 3:2 select the transfer type: 00 verify, 01 write to memory, 10 read from memory, 11 illegal. An unmasked single-mode request with type 11 is granted zero elements, and `err` is high in its done cycle.
- R6: The grant equals the smaller of `xfer_len` and the channel's live count. `done` is a one-cycle pulse that carries the grant on `done_count`. It comes one cycle after the last element, or one cycle after acceptance when the grant is zero.
- R7: Elements move one per clock, starting in the cycle after acceptance. Type 01 raises `mem_wr`, type 10 raises `mem_rd` and verify raises neither. The two strobes are never high together.
- R8: The first element uses the live address. Each later element is displaced by the element size: 1 byte for an 8-bit channel, or 2 bytes for a channel whose `WIDE_MASK` bit is 1 (channels 2 and 3 by default). The address moves up when mode bit 5 is 0 and down when it is 1, wrapping modulo 2^ADDR_W.
- R9: After a transfer that does not empty the channel, the live count has dropped by the grant and the live address has moved by the grant times the element size.
- R10: When an element brings the live count to zero, that channel's finished flag is set and its request flag is cleared. A `req_set` pulse sets the request flag. A later request on an emptied channel is granted zero elements.
- R11: When the live count reaches zero and mode bit 4 is 1, the live address and live count are reloaded from the base address and base count.
- R12: While `busy` is high, a new request is ignored and has no effect on any channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 2 | Channel addressed by the configuration write |
| cfg_sel | input | 2 | 0 base address, 1 base count, 2 mode byte |
| cfg_data | input | ADDR_W | Configuration value |
| chan_mask | input | N_CH | Per-channel mask; 1 blocks the channel |
| req_set | input | N_CH | Pulse that sets a channel's request flag |
| xfer_req | input | 1 | Transfer request, taken while idle |
| xfer_ch | input | 2 | Requested channel |
| xfer_len | input | CNT_W | Requested element count |
| busy | output | 1 | Engine is moving elements or reporting done |
| mem_wr | output | 1 | Write-to-memory strobe, one element |
| mem_rd | output | 1 | Read-from-memory strobe, one element |
| mem_addr | output | ADDR_W | Address of the current element |
| mem_wide | output | 1 | Current element is two bytes |
| done | output | 1 | One-cycle completion pulse |
| done_count | output | CNT_W | Granted element count, valid with done |
| err | output | 1 | Illegal transfer type, valid with done |
| tc_status | output | N_CH | Per-channel finished flags |
| req_status | output | N_CH | Per-channel request flags |
| rd_ch | input | 2 | Channel whose live registers are shown |
| rd_addr | output | ADDR_W | Live address of rd_ch |
| rd_count | output | CNT_W | Live count of rd_ch |

## Verification
The bench sweeps every channel through both directions and all three legal transfer types. For each setting it makes one request that is only partly granted and one that empties the channel. A design that clipped the grant to the wrong operand, or fired terminal count one element early or late, would show a wrong element count or wrong flags. A design that used the wrong element size on the two-byte channels would place strobes at the wrong addresses. A design that stepped the address before the first access would have its first strobe off by one element.

Separate cases cover the remaining corners. The address wrap below zero on a two-byte channel would expose a missing modulo or a size error. A reload that ignored the auto-initialise bit, or took its values from the live registers instead of the base registers, would leave the wrong readback after terminal count. A request on an already-emptied channel must get a zero grant and must not set the finished flag again. A request that arrives while the engine is busy would, if wrongly accepted, corrupt another channel's count or produce a second done pulse.

// File: rtl/dmaxfer_pkg.sv
package dmaxfer_pkg;

  typedef enum logic [1:0] {
    OP_DEMAND  = 2'b00,
    OP_SINGLE  = 2'b01,
    OP_BLOCK   = 2'b10,
    OP_CASCADE = 2'b11
  } op_mode_e;

  typedef enum logic [1:0] {
    XK_VERIFY  = 2'b00,
    XK_TOMEM   = 2'b01,
    XK_FROMMEM = 2'b10,
    XK_BAD     = 2'b11
  } xfer_kind_e;

  // Bit layout of the mode byte: [7:6] op, [5] down, [4] reload, [3:2] kind
  typedef struct packed {
    op_mode_e   op;
    logic       down;
    logic       reload;
    xfer_kind_e kind;
    logic [1:0] unused;
  } mode_t;

  typedef enum logic [1:0] {
    SEL_BASE_ADDR = 2'd0,
    SEL_BASE_CNT  = 2'd1,
    SEL_MODE      = 2'd2,
    SEL_NONE      = 2'd3
  } cfg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MOVE = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;

endpackage

// File: rtl/dmaxfer_grant.sv
module dmaxfer_grant
  import dmaxfer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  mode_t              mode,
  input  logic               masked,
  input  logic [CNT_W-1:0]   want,
  input  logic [CNT_W-1:0]   have,
  output logic [CNT_W-1:0]   grant,
  output logic               bad_kind
);

  function automatic logic [CNT_W-1:0] smaller(input logic [CNT_W-1:0] a,
                                               input logic [CNT_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  logic eligible;

  always_comb begin
    eligible = !masked && (mode.op == OP_SINGLE);
    bad_kind = eligible && (mode.kind == XK_BAD);
    if (eligible && !bad_kind) grant = smaller(want, have);
    else                       grant = '0;
  end

endmodule

// File: rtl/dmaxfer_chan_regs.sv
module dmaxfer_chan_regs
  import dmaxfer_pkg::*;
#(
  parameter int              N_CH      = 4,
  parameter int              ADDR_W    = 24,
  parameter int              CNT_W     = 16,
  parameter logic [N_CH-1:0] WIDE_MASK = '0,
  parameter int              CH_W      = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [CH_W-1:0]               cfg_ch,
  input  cfg_sel_e                      cfg_sel,
  input  logic [ADDR_W-1:0]             cfg_data,
  input  logic [N_CH-1:0]               req_set,
  input  logic                          step_en,
  input  logic [CH_W-1:0]               step_ch,
  output mode_t [N_CH-1:0]              mode_q,
  output logic  [N_CH-1:0][ADDR_W-1:0]  cur_addr,
  output logic  [N_CH-1:0][CNT_W-1:0]   cur_cnt,
  output logic  [N_CH-1:0]              tc_flags,
  output logic  [N_CH-1:0]              req_flags,
  output logic                          tc_evt
);

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a,
                                                  input logic down,
                                                  input logic wide);
    logic [ADDR_W-1:0] d;
    d = wide ? ADDR_W'(2) : ADDR_W'(1);
    return down ? (a - d) : (a + d);
  endfunction

  // terminal count event: the stepped element is the last one in the channel
  assign tc_evt = step_en && (cur_cnt[step_ch] == CNT_W'(1));

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [ADDR_W-1:0] base_a, live_a;
    logic [CNT_W-1:0]  base_c, live_c;
    mode_t             mode_r;
    logic              tc_r, rq_r;
    logic              wr_me, hit, last;

    assign wr_me = cfg_we && (cfg_ch == CH_W'(c));
    assign hit   = step_en && (step_ch == CH_W'(c));
    assign last  = hit && (live_c == CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_a <= '0;
        base_c <= '0;
        live_a <= '0;
        live_c <= '0;
        mode_r <= '0;
        tc_r   <= 1'b0;
        rq_r   <= 1'b0;
      end else begin
        if (wr_me) begin
          case (cfg_sel)
            SEL_BASE_ADDR: base_a <= cfg_data;
            SEL_BASE_CNT: begin
              base_c <= cfg_data[CNT_W-1:0];
              tc_r   <= 1'b0;
            end
            SEL_MODE:      mode_r <= mode_t'(cfg_data[7:0]);
            default: ;
          endcase
        end
        // live registers: the engine's step has priority over a host write
        if (hit) begin
          if (last && mode_r.reload) begin
            live_a <= base_a;
            live_c <= base_c;
          end else begin
            live_a <= step_addr(live_a, mode_r.down, WIDE_MASK[c]);
            live_c <= live_c - CNT_W'(1);
          end
        end else if (wr_me && cfg_sel == SEL_BASE_ADDR) begin
          live_a <= cfg_data;
        end else if (wr_me && cfg_sel == SEL_BASE_CNT) begin
          live_c <= cfg_data[CNT_W-1:0];
        end
        if (last)            tc_r <= 1'b1;
        if (last)            rq_r <= 1'b0;
        else if (req_set[c]) rq_r <= 1'b1;
      end
    end

    assign mode_q[c]    = mode_r;
    assign cur_addr[c]  = live_a;
    assign cur_cnt[c]   = live_c;
    assign tc_flags[c]  = tc_r;
    assign req_flags[c] = rq_r;
  end

endmodule

// File: rtl/dmaxfer_seq.sv
module dmaxfer_seq
  import dmaxfer_pkg::*;
#(
  parameter int CH_W  = 2,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_req,
  input  logic [CH_W-1:0]   xfer_ch,
  input  logic [CNT_W-1:0]  grant,
  input  logic              bad_kind,
  input  xfer_kind_e        kind_in,
  output logic              accept,
  output logic              busy,
  output logic              step_en,
  output logic [CH_W-1:0]   act_ch,
  output logic              mem_wr,
  output logic              mem_rd,
  output logic              done,
  output logic [CNT_W-1:0]  done_count,
  output logic              err
);

  seq_state_e        state;
  logic [CNT_W-1:0]  left, granted;
  logic              err_q;
  xfer_kind_e        kind_q;

  assign accept = (state == ST_IDLE) && xfer_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      act_ch  <= '0;
      left    <= '0;
      granted <= '0;
      err_q   <= 1'b0;
      kind_q  <= XK_VERIFY;
    end else begin
      case (state)
        ST_IDLE: if (xfer_req) begin
          act_ch  <= xfer_ch;
          left    <= grant;
          granted <= grant;
          err_q   <= bad_kind;
          kind_q  <= kind_in;
          state   <= (grant == '0) ? ST_DONE : ST_MOVE;
        end
        ST_MOVE: begin
          left <= left - CNT_W'(1);
          if (left == CNT_W'(1)) state <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (state != ST_IDLE);
  assign step_en    = (state == ST_MOVE);
  assign mem_wr     = step_en && (kind_q == XK_TOMEM);
  assign mem_rd     = step_en && (kind_q == XK_FROMMEM);
  assign done       = (state == ST_DONE);
  assign done_count = done ? granted : '0;
  assign err        = done && err_q;

endmodule

// File: rtl/dmaxfer_engine.sv
module dmaxfer_engine
  import dmaxfer_pkg::*;
#(
  parameter int              N_CH      = 4,
  parameter int              ADDR_W    = 24,
  parameter int              CNT_W     = 16,
  parameter logic [N_CH-1:0] WIDE_MASK = 4'b1100,
  localparam int             CH_W      = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CH_W-1:0]   cfg_ch,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_data,
  input  logic [N_CH-1:0]   chan_mask,
  input  logic [N_CH-1:0]   req_set,
  input  logic              xfer_req,
  input  logic [CH_W-1:0]   xfer_ch,
  input  logic [CNT_W-1:0]  xfer_len,
  output logic              busy,
  output logic              mem_wr,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_wide,
  output logic              done,
  output logic [CNT_W-1:0]  done_count,
  output logic              err,
  output logic [N_CH-1:0]   tc_status,
  output logic [N_CH-1:0]   req_status,
  input  logic [CH_W-1:0]   rd_ch,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_count
);

  mode_t [N_CH-1:0]             mode_q;
  logic  [N_CH-1:0][ADDR_W-1:0] cur_addr;
  logic  [N_CH-1:0][CNT_W-1:0]  cur_cnt;

  // named internal events, also seen by the bound checker
  logic              accept, step_en, tc_evt, bad_kind, act_down;
  logic [CH_W-1:0]   act_ch;
  logic [CNT_W-1:0]  grant, req_cnt;
  mode_t             req_mode;

  assign req_mode = mode_q[xfer_ch];
  assign req_cnt  = cur_cnt[xfer_ch];

  dmaxfer_chan_regs #(
    .N_CH(N_CH), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
    .WIDE_MASK(WIDE_MASK), .CH_W(CH_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel_e'(cfg_sel)),
    .cfg_data(cfg_data), .req_set(req_set),
    .step_en(step_en), .step_ch(act_ch),
    .mode_q(mode_q), .cur_addr(cur_addr), .cur_cnt(cur_cnt),
    .tc_flags(tc_status), .req_flags(req_status), .tc_evt(tc_evt)
  );

  dmaxfer_grant #(.CNT_W(CNT_W)) u_grant (
    .mode(req_mode), .masked(chan_mask[xfer_ch]),
    .want(xfer_len), .have(req_cnt),
    .grant(grant), .bad_kind(bad_kind)
  );

  dmaxfer_seq #(.CH_W(CH_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .xfer_req(xfer_req), .xfer_ch(xfer_ch),
    .grant(grant), .bad_kind(bad_kind), .kind_in(req_mode.kind),
    .accept(accept), .busy(busy), .step_en(step_en), .act_ch(act_ch),
    .mem_wr(mem_wr), .mem_rd(mem_rd),
    .done(done), .done_count(done_count), .err(err)
  );

  assign act_down = mode_q[act_ch].down;
  assign mem_addr = cur_addr[act_ch];
  assign mem_wide = WIDE_MASK[act_ch];
  assign rd_addr  = cur_addr[rd_ch];
  assign rd_count = cur_cnt[rd_ch];

endmodule

// File: rtl/dmaxfer_engine_chk.sv
module dmaxfer_engine_chk #(
  parameter int N_CH   = 4,
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16,
  parameter int CH_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_wr,
  input logic              mem_rd,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_wide,
  input logic              act_down,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              accept,
  input logic [CNT_W-1:0]  grant,
  input logic [CNT_W-1:0]  xfer_len,
  input logic [CH_W-1:0]   xfer_ch,
  input logic [N_CH-1:0]   chan_mask,
  input logic [CNT_W-1:0]  req_cnt,
  input logic              tc_evt,
  input logic [CH_W-1:0]   act_ch,
  input logic [N_CH-1:0]   tc_status,
  input logic [N_CH-1:0]   req_status
);

  logic [ADDR_W-1:0] elem_sz;
  assign elem_sz = mem_wide ? ADDR_W'(2) : ADDR_W'(1);

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr && mem_rd));

  // R7
  strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr || mem_rd) |-> (busy && !done));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  grant_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (grant <= xfer_len && grant <= req_cnt));

  // R3
  masked_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && chan_mask[xfer_ch]) |-> (grant == '0));

  // R5
  err_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  // R10
  tc_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc_evt |=> (tc_status[$past(act_ch)] && !req_status[$past(act_ch)]));

  // R8
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_wr || mem_rd) && $past(mem_wr || mem_rd) && !$past(tc_evt)) |->
      (mem_addr == (act_down ? $past(mem_addr) - elem_sz : $past(mem_addr) + elem_sz)));

  // R12
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(act_ch));

endmodule

bind dmaxfer_engine dmaxfer_engine_chk #(
  .N_CH(N_CH), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .CH_W(CH_W)
) u_chk (.*);

// File: tb/dmaxfer_engine_test.sv
`timescale 1ns/1ps
module dmaxfer_engine_test;

  localparam int N_CH = 4, ADDR_W = 24, CNT_W = 16, CH_W = 2;
  localparam logic [3:0] WIDE = 4'b1100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0; logic [1:0] cfg_ch = 0, cfg_sel = 0; logic [ADDR_W-1:0] cfg_data = 0;
  logic [3:0] chan_mask = 0, req_set = 0;
  logic xfer_req = 0; logic [1:0] xfer_ch = 0; logic [CNT_W-1:0] xfer_len = 0;
  logic busy, mem_wr, mem_rd, mem_wide, done, err;
  logic [ADDR_W-1:0] mem_addr, rd_addr; logic [CNT_W-1:0] done_count, rd_count;
  logic [3:0] tc_status, req_status; logic [1:0] rd_ch = 0;

  always #2 clk = ~clk;

  dmaxfer_engine uut (.*);

  int n_chk = 0, n_fail = 0;
  logic [ADDR_W-1:0] m_ba[4], m_a[4];
  logic [CNT_W-1:0]  m_bc[4], m_c[4];
  logic [7:0]        m_mode[4];
  logic [3:0]        m_tc = 0, m_rq = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input int ch, input int sel, input logic [ADDR_W-1:0] d);
    cfg_we = 1; cfg_ch = 2'(ch); cfg_sel = 2'(sel); cfg_data = d;
    @(posedge clk); @(negedge clk); cfg_we = 0;
    if (sel == 0) begin m_ba[ch] = d; m_a[ch] = d; end
    if (sel == 1) begin m_bc[ch] = d[CNT_W-1:0]; m_c[ch] = d[CNT_W-1:0]; m_tc[ch] = 0; end
    if (sel == 2) m_mode[ch] = d[7:0];
  endtask

  task automatic readback(input int ch, input string tag);
    rd_ch = 2'(ch); #1;
    chk(rd_addr == m_a[ch], {tag, " addr"}, rd_addr, m_a[ch]);
    chk(rd_count == m_c[ch], {tag, " count"}, rd_count, m_c[ch]);
  endtask

  task automatic run(input int ch, input int len, input int intrude, input string tag);
    logic ok_mode, exp_err; logic [1:0] kind; int g, elems; logic [ADDR_W-1:0] sz;
    kind    = m_mode[ch][3:2];
    ok_mode = !chan_mask[ch] && m_mode[ch][7:6] == 2'b01;
    exp_err = ok_mode && kind == 2'b11;
    g  = (ok_mode && kind != 2'b11) ? ((len < int'(m_c[ch])) ? len : int'(m_c[ch])) : 0;
    sz = WIDE[ch] ? 2 : 1;
    xfer_req = 1; xfer_ch = 2'(ch); xfer_len = CNT_W'(len);
    @(posedge clk); @(negedge clk); xfer_req = 0;
    elems = 0;
    for (int k = 0; k < 100; k++) begin
      if (k == 0 && intrude >= 0) begin
        xfer_req = 1; xfer_ch = 2'(intrude); xfer_len = 5;
      end else xfer_req = 0;
      if (done) break;
      // R7 strobe kind per element
      chk(mem_wr == (kind == 2'b01) && mem_rd == (kind == 2'b10),
          {tag, " R7 strobe"}, {mem_wr, mem_rd}, kind);
      if (kind != 2'b00) begin
        chk(mem_addr == m_a[ch], {tag, " R8 element address"}, mem_addr, m_a[ch]);
        chk(mem_wide == WIDE[ch], {tag, " R8 size"}, mem_wide, WIDE[ch]);
      end
      elems++;
      if (m_c[ch] == 1) begin
        m_tc[ch] = 1; m_rq[ch] = 0;
        if (m_mode[ch][4]) begin m_a[ch] = m_ba[ch]; m_c[ch] = m_bc[ch]; end
        else begin m_a[ch] = m_mode[ch][5] ? m_a[ch] - sz : m_a[ch] + sz; m_c[ch] = 0; end
      end else begin
        m_a[ch] = m_mode[ch][5] ? m_a[ch] - sz : m_a[ch] + sz; m_c[ch] = m_c[ch] - 1;
      end
      @(negedge clk);
    end
    chk(done, {tag, " R6 done seen"}, done, 1);
    chk(elems == g, {tag, " R7 one element per clock"}, elems, g);
    chk(done_count == CNT_W'(g), {tag, " R6 grant"}, done_count, g);
    chk(err == exp_err, {tag, " R5 err"}, err, exp_err);
    chk(tc_status == m_tc && req_status == m_rq, {tag, " R10 flags"},
        {tc_status, req_status}, {m_tc, m_rq});
    @(negedge clk); xfer_req = 0;
    chk(!done && !busy, {tag, " R6 done one cycle"}, {done, busy}, 0);
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int c = 0; c < 4; c++) begin m_ba[c] = 0; m_a[c] = 0; m_bc[c] = 0; m_c[c] = 0; m_mode[c] = 0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !mem_wr && !mem_rd && !done, "R1 idle outputs", {busy, mem_wr, mem_rd, done}, 0);
    chk(tc_status == 0 && req_status == 0, "R1 flags", {tc_status, req_status}, 0);
    rst_n = 1; @(negedge clk);
    for (int c = 0; c < 4; c++) readback(c, "R1 reset");
    run(0, 3, -1, "R1 unprogrammed mode");

    // sweep: channel x direction x transfer type, partial then emptying request
    for (int c = 0; c < 4; c++)
      for (int d = 0; d < 2; d++)
        for (int t = 0; t < 3; t++) begin
          cfg(c, 0, ADDR_W'(24'h001000 * (c + 1) + d * 24'h80));
          cfg(c, 1, 5);
          cfg(c, 2, {8'b0, 2'b01, d[0], 1'b0, t[1:0], 2'b00});
          readback(c, "R2 programmed");
          run(c, 2, -1, "sweep partial");
          readback(c, "R9 after partial");
          req_set = 4'(1 << c); @(negedge clk); req_set = 0; m_rq[c] = 1;
          chk(req_status[c], "R10 req_set", req_status, m_rq);
          run(c, 7, -1, "sweep emptying");
          readback(c, "R10 emptied");
          run(c, 4, -1, "R10 empty channel zero grant");
        end

    // R11 auto-initialise on a wide channel
    cfg(2, 0, 24'h002000); cfg(2, 1, 3); cfg(2, 2, {16'b0, 8'b0101_0100});
    run(2, 3, -1, "R11 reload");
    readback(2, "R11 reload restores base");
    run(2, 5, -1, "R11 second pass");

    // R3 masked channel
    cfg(1, 0, 24'h000300); cfg(1, 1, 6); cfg(1, 2, {16'b0, 8'b0100_1000});
    chan_mask = 4'b0010;
    run(1, 4, -1, "R3 masked");
    readback(1, "R3 masked unchanged");
    chan_mask = 0;

    // R4 refused operating modes
    for (int op = 0; op < 4; op++) if (op != 1) begin
      cfg(1, 2, {16'b0, op[1:0], 6'b00_0100});
      run(1, 4, -1, "R4 refused mode");
      readback(1, "R4 unchanged");
    end

    // R5 illegal type
    cfg(1, 2, {16'b0, 8'b0100_1100});
    run(1, 2, -1, "R5 illegal type");
    readback(1, "R5 unchanged");

    // R8 downward wrap on a wide channel
    cfg(3, 0, 0); cfg(3, 1, 3); cfg(3, 2, {16'b0, 8'b0110_1000});
    run(3, 2, -1, "R8 wrap");
    readback(3, "R8 wrap end address");

    // R12 request while busy is ignored
    cfg(0, 0, 24'h000040); cfg(0, 1, 4); cfg(0, 2, {16'b0, 8'b0100_0100});
    cfg(1, 1, 6); cfg(1, 2, {16'b0, 8'b0100_0100});
    run(0, 3, 1, "R12 busy intrusion");
    readback(1, "R12 other channel untouched");
    readback(0, "R12 own channel");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule